// File: doc/BRIEF.md
# 5B/4B Receive Delimiter Decoder

This block sits behind the descrambler of a 100BASE-TX receive path. It takes the recovered bit stream one bit per transfer and works out where the 5-bit code-group boundaries lie. To do this it watches for a long run of idle ones that ends in the start-of-stream pair. Once locked, it turns each code-group into a receive word for the MAC. The word carries a 4-bit data nibble and the data-valid, error and carrier flags. The block also counts every false-carrier nibble in a saturating counter.

The start pair is handed on as two preamble nibbles. The end pair, or two idles in a row, closes the frame with one carrier-off word. Control groups that are out of place are flagged as errors. A start attempt that does not open with the proper pair becomes a false-carrier event. That event lasts until two idles arrive.

Both sides of the block are valid/ready streams. An output word stays on the port, unchanged, until the consumer takes it. While a word is waiting and `m_ready` is low, `s_ready` goes low, so no input bit is lost. Each code-group yields at most one word, so no further queueing is needed.

Top module: `rx5b_decoder`

## Requirements
- R1: Bits arrive most significant bit of each group first. Alignment is acquired only when a 0 bit follows at least MIN_ONES consecutive 1 bits. That 0 is taken as the third bit of a group. While unaligned, no word is emitted.
- R2: A first group of 11000 followed directly by 10001 yields two words with rxd=0101, dv=1, crs=1 and er=0.
- R3: Inside a frame, each of the 16 data groups is decoded to its nibble with dv=1, crs=1 and er=0. The 16 data groups are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101, which give the nibbles 0 to F in that order.
- R4: Inside a frame, a 01101 group followed directly by 00111 yields one word with crs=0, dv=0, er=0 and rxd=0000. The block then returns to searching. No word is emitted for the 00111 group.
- R5: Inside a frame, two consecutive 11111 groups yield the same closing word as R4, and the block returns to searching.
- R6: Inside a frame, the following groups each yield one word with er=1, dv=1, crs=1 and rxd=0000: 00100, any non-data group not listed above, 01101 not followed by 00111, 00111 not preceded by 01101, 11000, 10001, and a single 11111.
- R7: If the first group is not 11000, or 11000 is not followed by 10001, a false-carrier event starts. Each group then yields rxd=1110, er=1, crs=1 and dv=0 until a pair of 11111 groups arrives. The first group of that pair yields the closing word of R4.
- R8: `err_cnt` rises by one for each false-carrier word of R7 and holds at 2^CNT_W-1.
- R9: A high `err_clr` at a clock edge sets `err_cnt` to 0.
- R10: While `m_valid` is high and `m_ready` is low, the output word stays stable and `s_ready` is low. Words leave in group order and none is dropped.
- R11: During and right after reset, `m_valid` is 0, `err_cnt` is 0, `s_ready` is 1 and the block is searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input bit is valid |
| s_ready | output | 1 | Block accepts the input bit |
| s_bit | input | 1 | Descrambled line bit |
| m_valid | output | 1 | Output word is valid |
| m_ready | input | 1 | Consumer takes the output word |
| m_rxd | output | 4 | Receive nibble |
| m_dv | output | 1 | Receive data valid |
| m_er | output | 1 | Receive error |
| m_crs | output | 1 | Carrier sense |
| err_clr | input | 1 | Synchronous clear of the error counter |
| err_cnt | output | CNT_W | Saturating false-carrier nibble count |

## Verification
The bench builds the block with CNT_W=3 and the default MIN_ONES of 12. The narrow counter reaches its ceiling of 7 after four false-carrier cases. That lets both saturation and clearing be seen within a short run. The full idle threshold keeps the short-run noise test meaningful. The same vector table is then run a second time with gaps on both handshakes, which exercises the stall path on every frame kind.

// File: rtl/rx5b_pkg.sv
package rx5b_pkg;

  typedef enum logic [2:0] {
    ST_SEARCH = 3'd0,
    ST_FIRST  = 3'd1,
    ST_SECOND = 3'd2,
    ST_FRAME  = 3'd3,
    ST_BAD    = 3'd4
  } fr_state_e;

  localparam logic [4:0] GRP_IDLE = 5'b11111;
  localparam logic [4:0] GRP_SSD1 = 5'b11000;
  localparam logic [4:0] GRP_SSD2 = 5'b10001;
  localparam logic [4:0] GRP_ESD1 = 5'b01101;
  localparam logic [4:0] GRP_ESD2 = 5'b00111;

  typedef struct packed {
    logic       crs;
    logic       dv;
    logic       er;
    logic [3:0] rxd;
  } rx_word_t;

  // returns {is_data, nibble}
  function automatic logic [4:0] dec5(input logic [4:0] g);
    case (g)
      5'b11110: dec5 = 5'h10;
      5'b01001: dec5 = 5'h11;
      5'b10100: dec5 = 5'h12;
      5'b10101: dec5 = 5'h13;
      5'b01010: dec5 = 5'h14;
      5'b01011: dec5 = 5'h15;
      5'b01110: dec5 = 5'h16;
      5'b01111: dec5 = 5'h17;
      5'b10010: dec5 = 5'h18;
      5'b10011: dec5 = 5'h19;
      5'b10110: dec5 = 5'h1A;
      5'b10111: dec5 = 5'h1B;
      5'b11010: dec5 = 5'h1C;
      5'b11011: dec5 = 5'h1D;
      5'b11100: dec5 = 5'h1E;
      5'b11101: dec5 = 5'h1F;
      default:  dec5 = 5'h00;
    endcase
  endfunction

endpackage

// File: rtl/rx5b_aligner.sv
module rx5b_aligner #(
  parameter int MIN_ONES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       bit_in,
  input  logic       locked,
  output logic       start,
  output logic       grp_done,
  output logic [4:0] grp
);
  localparam int OW = $clog2(MIN_ONES + 1);
  localparam logic [OW-1:0] ONES_MAX = OW'(MIN_ONES);

  logic [3:0]    hist_q;
  logic [2:0]    ph_q;
  logic [OW-1:0] ones_q;

  assign start    = acc && !locked && !bit_in && (ones_q >= ONES_MAX);
  assign grp_done = acc && locked && (ph_q == 3'd4);
  assign grp      = {hist_q, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      ph_q   <= '0;
      ones_q <= '0;
    end else if (acc) begin
      hist_q <= {hist_q[2:0], bit_in};
      if (!bit_in)
        ones_q <= '0;
      else if (ones_q != ONES_MAX)
        ones_q <= ones_q + 1'b1;
      if (start)
        ph_q <= 3'd3;
      else if (locked)
        ph_q <= (ph_q == 3'd4) ? 3'd0 : ph_q + 3'd1;
    end
  end
endmodule

// File: rtl/rx5b_framer.sv
module rx5b_framer
  import rx5b_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       grp_done,
  input  logic [4:0] grp,
  input  logic       m_ready,
  output logic       locked,
  output logic       out_valid,
  output rx_word_t   out_word,
  output logic       bad_inc
);
  localparam rx_word_t W_PRE = '{crs: 1'b1, dv: 1'b1, er: 1'b0, rxd: 4'b0101};
  localparam rx_word_t W_END = '{crs: 1'b0, dv: 1'b0, er: 1'b0, rxd: 4'b0000};
  localparam rx_word_t W_ERR = '{crs: 1'b1, dv: 1'b1, er: 1'b1, rxd: 4'b0000};
  localparam rx_word_t W_FC  = '{crs: 1'b1, dv: 1'b0, er: 1'b1, rxd: 4'b1110};

  fr_state_e st_q, st_n;
  logic [4:0] prev_q, prev_n;
  logic       pk_q, pk_n;
  logic       emit;
  rx_word_t   word_n;
  logic [4:0] pd;

  assign locked = (st_q != ST_SEARCH);
  assign pd     = dec5(prev_q);

  always_comb begin
    st_n    = st_q;
    prev_n  = prev_q;
    pk_n    = pk_q;
    emit    = 1'b0;
    word_n  = W_END;
    bad_inc = 1'b0;
    case (st_q)
      ST_SEARCH: if (start) st_n = ST_FIRST;
      ST_FIRST: if (grp_done) begin
        prev_n = grp;
        st_n   = ST_SECOND;
      end
      ST_SECOND: if (grp_done) begin
        emit   = 1'b1;
        prev_n = grp;
        if (prev_q == GRP_SSD1 && grp == GRP_SSD2) begin
          word_n = W_PRE;
          pk_n   = 1'b1;
          st_n   = ST_FRAME;
        end else begin
          word_n  = W_FC;
          bad_inc = 1'b1;
          st_n    = ST_BAD;
        end
      end
      ST_FRAME: if (grp_done) begin
        emit   = 1'b1;
        prev_n = grp;
        pk_n   = 1'b0;
        if (pk_q)
          word_n = W_PRE;
        else if ((prev_q == GRP_IDLE && grp == GRP_IDLE) ||
                 (prev_q == GRP_ESD1 && grp == GRP_ESD2)) begin
          word_n = W_END;
          st_n   = ST_SEARCH;
        end else if (pd[4])
          word_n = '{crs: 1'b1, dv: 1'b1, er: 1'b0, rxd: pd[3:0]};
        else
          word_n = W_ERR;
      end
      ST_BAD: if (grp_done) begin
        emit   = 1'b1;
        prev_n = grp;
        if (prev_q == GRP_IDLE && grp == GRP_IDLE) begin
          word_n = W_END;
          st_n   = ST_SEARCH;
        end else begin
          word_n  = W_FC;
          bad_inc = 1'b1;
        end
      end
      default: st_n = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_SEARCH;
      prev_q    <= '0;
      pk_q      <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= W_END;
    end else begin
      st_q   <= st_n;
      prev_q <= prev_n;
      pk_q   <= pk_n;
      if (emit) begin
        out_valid <= 1'b1;
        out_word  <= word_n;
      end else if (m_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx5b_errcnt.sv
module rx5b_errcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (inc && cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rx5b_decoder.sv
module rx5b_decoder
  import rx5b_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int MIN_ONES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_bit,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [3:0]       m_rxd,
  output logic             m_dv,
  output logic             m_er,
  output logic             m_crs,
  input  logic             err_clr,
  output logic [CNT_W-1:0] err_cnt
);
  logic       acc, locked, start, grp_done, bad_inc;
  logic [4:0] grp;
  rx_word_t   word;

  assign s_ready = !m_valid || m_ready;
  assign acc     = s_valid && s_ready;

  rx5b_aligner #(.MIN_ONES(MIN_ONES)) u_align (
    .clk(clk), .rst_n(rst_n), .acc(acc), .bit_in(s_bit), .locked(locked),
    .start(start), .grp_done(grp_done), .grp(grp)
  );

  rx5b_framer u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .grp_done(grp_done), .grp(grp),
    .m_ready(m_ready), .locked(locked), .out_valid(m_valid), .out_word(word),
    .bad_inc(bad_inc)
  );

  rx5b_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(err_clr), .inc(bad_inc), .cnt(err_cnt)
  );

  assign m_rxd = word.rxd;
  assign m_dv  = word.dv;
  assign m_er  = word.er;
  assign m_crs = word.crs;
endmodule

// File: rtl/rx5b_decoder_chk.sv
module rx5b_decoder_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             m_valid,
  input logic             m_ready,
  input logic [3:0]       m_rxd,
  input logic             m_dv,
  input logic             m_er,
  input logic             m_crs,
  input logic             err_clr,
  input logic [CNT_W-1:0] err_cnt
);
  // R10
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable({m_crs, m_dv, m_er, m_rxd}));

  // R2
  dv_has_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_dv |-> m_crs);

  // R7
  false_carrier_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_er && !m_dv |-> m_crs && m_rxd == 4'b1110);

  // R4
  close_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_crs |-> !m_dv && !m_er && m_rxd == 4'b0000);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + CNT_W'(1)));

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> err_cnt == '0);
endmodule

bind rx5b_decoder rx5b_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_rxd(m_rxd), .m_dv(m_dv), .m_er(m_er), .m_crs(m_crs),
  .err_clr(err_clr), .err_cnt(err_cnt)
);

// File: tb/sim_rx5b_decoder.sv
module sim_rx5b_decoder;
  localparam int CW   = 3;
  localparam int MAXC = 7;

  localparam logic [4:0] I_ = 5'b11111, J_ = 5'b11000, K_ = 5'b10001;
  localparam logic [4:0] T_ = 5'b01101, R_ = 5'b00111, H_ = 5'b00100, V_ = 5'b00110;
  localparam logic [4:0] D1 = 5'b01001, D2 = 5'b10100, D3 = 5'b10101, D4 = 5'b01010;
  localparam logic [4:0] D5 = 5'b01011, D6 = 5'b01110, D7 = 5'b01111, D8 = 5'b10010;
  localparam logic [4:0] D9 = 5'b10011, DA = 5'b10110, DC = 5'b11010, Z_ = 5'b00000;
  localparam logic [6:0] PRE = 7'b110_0101, EW = 7'b000_0000;
  localparam logic [6:0] FE = 7'b111_0000, FC = 7'b101_1110;
  localparam int NCASE = 9;

  // {group count, eight groups}
  localparam logic [43:0] STIM [0:NCASE-1] = '{
    {4'd8, J_, K_, D5, DA, T_, R_, I_, I_},
    {4'd6, J_, K_, D3, I_, I_, I_, Z_, Z_},
    {4'd8, J_, K_, D1, H_, D2, T_, R_, I_},
    {4'd7, J_, K_, V_, D7, T_, R_, I_, Z_},
    {4'd8, J_, K_, D4, T_, D6, T_, R_, I_},
    {4'd7, J_, K_, R_, D8, T_, R_, I_, Z_},
    {4'd5, DC, D5, I_, I_, I_, Z_, Z_, Z_},
    {4'd5, J_, D9, I_, I_, I_, Z_, Z_, Z_},
    {4'd7, J_, K_, I_, D2, T_, R_, I_, Z_}
  };
  // {word count, eight words {crs,dv,er,rxd}}
  localparam logic [59:0] EXPV [0:NCASE-1] = '{
    {4'd5, PRE, PRE, 7'b110_0101, 7'b110_1010, EW, EW, EW, EW},
    {4'd4, PRE, PRE, 7'b110_0011, EW, EW, EW, EW, EW},
    {4'd6, PRE, PRE, 7'b110_0001, FE, 7'b110_0010, EW, EW, EW},
    {4'd5, PRE, PRE, FE, 7'b110_0111, EW, EW, EW, EW},
    {4'd6, PRE, PRE, 7'b110_0100, FE, 7'b110_0110, EW, EW, EW},
    {4'd5, PRE, PRE, FE, 7'b110_1000, EW, EW, EW, EW},
    {4'd3, FC, FC, EW, EW, EW, EW, EW, EW},
    {4'd3, FC, FC, EW, EW, EW, EW, EW, EW},
    {4'd5, PRE, PRE, FE, 7'b110_0010, EW, EW, EW, EW}
  };
  localparam int BADN [0:NCASE-1] = '{0, 0, 0, 0, 0, 0, 2, 2, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_bit = 1'b0, m_ready = 1'b1, err_clr = 1'b0;
  logic s_ready, m_valid, m_dv, m_er, m_crs;
  logic [3:0] m_rxd;
  logic [CW-1:0] err_cnt;

  always #10 clk = ~clk;

  rx5b_decoder #(.CNT_W(CW), .MIN_ONES(12)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_bit(s_bit),
    .m_valid(m_valid), .m_ready(m_ready), .m_rxd(m_rxd), .m_dv(m_dv), .m_er(m_er),
    .m_crs(m_crs), .err_clr(err_clr), .err_cnt(err_cnt)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0, throttle = 1'b0;
  logic bits [0:511];
  int nbits = 0, bidx = 0, nrec = 0, badtot = 0;
  logic [6:0] rec [0:15];
  logic hold_p = 1'b0;
  logic [6:0] hold_v = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_sum();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    logic [6:0] cur;
    @(negedge clk);
    cyc++;
    m_ready = throttle ? (cyc % 3 != 2) : 1'b1;
    s_valid = (bidx < nbits) && (!throttle || (cyc % 4 != 1));
    s_bit   = s_valid ? bits[bidx] : 1'b0;
    #1;
    cur = {m_crs, m_dv, m_er, m_rxd};
    if (hold_p) check(m_valid && cur == hold_v, "R10 held word", int'(cur), int'(hold_v));
    if (m_valid && !m_ready) check(!s_ready, "R10 stall", int'(s_ready), 0);
    hold_p = m_valid && !m_ready;
    hold_v = cur;
    if (m_valid && m_ready) begin
      if (nrec < 16) rec[nrec] = cur;
      nrec++;
    end
    if (s_valid && s_ready) bidx++;
  endtask

  task automatic push_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) begin
      bits[nbits] = g[i];
      nbits++;
    end
  endtask

  task automatic run_bits();
    while (bidx < nbits) step();
    repeat (6) step();
  endtask

  task automatic clear_stream();
    nbits = 0;
    bidx  = 0;
    nrec  = 0;
  endtask

  function automatic string tag_of(input logic [6:0] w, input int c);
    if (w == PRE) return "R2";
    if (w == EW)  return (c == 1) ? "R5" : "R4";
    if (w == FE)  return "R6";
    if (w == FC)  return "R7";
    return "R3";
  endfunction

  task automatic run_case(input int c);
    int ng, nw, expc;
    logic [6:0] ew;
    clear_stream();
    repeat (3) push_grp(I_);
    ng = int'(STIM[c][43:40]);
    for (int k = 0; k < ng; k++) push_grp(STIM[c][39-5*k -: 5]);
    run_bits();
    nw = int'(EXPV[c][59:56]);
    check(nrec == nw, "R10 word count", nrec, nw);
    for (int k = 0; k < nw && k < nrec; k++) begin
      ew = EXPV[c][55-7*k -: 7];
      check(rec[k] == ew, tag_of(ew, c), int'(rec[k]), int'(ew));
    end
    badtot += BADN[c];
    expc = (badtot > MAXC) ? MAXC : badtot;
    check(int'(err_cnt) == expc, "R8 counter", int'(err_cnt), expc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_sum();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11 during reset
    check(!m_valid, "R11 valid in reset", int'(m_valid), 0);
    check(err_cnt == '0, "R11 count in reset", int'(err_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check(!m_valid && s_ready, "R11 after reset", int'({m_valid, s_ready}), 1);

    // R1: too few leading ones, J/K must be ignored
    clear_stream();
    push_grp(5'b01111);
    push_grp(5'b11110);
    push_grp(J_); push_grp(K_); push_grp(D5); push_grp(D4);
    run_bits();
    check(nrec == 0, "R1 short idle run", nrec, 0);

    for (int pass = 0; pass < 2; pass++) begin
      throttle = (pass == 1);
      for (int c = 0; c < NCASE; c++) run_case(c);
    end
    throttle = 1'b0;

    // R8 saturation reached after four false-carrier cases
    check(int'(err_cnt) == MAXC, "R8 saturated", int'(err_cnt), MAXC);
    err_clr = 1'b1;
    step();
    err_clr = 1'b0;
    step();
    check(err_cnt == '0, "R9 clear", int'(err_cnt), 0);

    // R7 then R9: counting restarts from zero
    badtot = 0;
    run_case(6);
    finish_sum();
  end
endmodule